// File: doc/BRIEF.md
# Indirect Control Space Decoder

This block serves single-byte host accesses made through the data port of an indirect-access display controller. The caller supplies the shared 12-bit pointer, the 2-bit component index, a read or a write strobe and the write byte. Pointer bits [11:8] pick one of three control spaces. Space 0x1 holds a cursor colour store. Space 0x2 holds a small register file: a fixed identity code, a fixed revision code, single-byte registers and two three-byte registers. Space 0x3 holds a 16-entry table of 24-bit window type words.

Window words change only as a whole. Bytes arrive in component order and are assembled in a staging register. The word is committed to the table on its third byte. A read of component 0 takes a snapshot of the addressed entry into the same staging register, and components 1 and 2 are then read from that snapshot.

For every access the block returns the read byte and at most one advance request. A triplet request asks the pointer logic to step the component index. A single-step request asks it to move the pointer to the next location. Pointer storage and the palette array are held outside this block.

Top module: `ctl_space_dec`

## Requirements
- R1: While rst_ni is low, rdata_o, adv_trip_o and adv_step_o are 0. Reset clears every stored register, cursor colour byte, table entry and the staging register to 0.
- R2: ptr_i[11:8] selects the space: 0x1 is cursor colour, 0x2 is registers, 0x3 is the window table. With any other value a read returns 0, no advance is requested, and a write changes no stored state.
- R3: In register space, low byte 0x00 reads 0x2A and low byte 0x20 reads 0x0A, and both request a single step. A write to 0x00 stores nothing but still requests a single step. A write to 0x20, and any access to another low byte of 0x10 or above, returns 0 and requests nothing.
- R4: Register low bytes 0x01 to 0x0D each store one byte. The component index is ignored. Each read or write requests a single step.
- R5: Register low bytes 0x0E and 0x0F each store three bytes selected by component index 0 to 2. Each read or write requests a triplet advance. With index 3, a write stores nothing and a read returns 0, but a triplet advance is still requested.
- R6: A cursor write with low byte below 4 stores byte [low byte][index] and requests a triplet advance. A cursor read with low byte below 2 returns that byte and requests a triplet advance. Any other cursor access returns 0 and requests nothing. Index 3 holds no byte.
- R7: A table write with index 0 loads the staging byte [7:0] and clears bits [23:8]. Index 1 loads bits [15:8]. Index 2 loads bits [23:16] and commits the whole staging word to entry ptr_i[3:0]. The entry does not change before that commit.
- R8: A table read with index 0 returns bits [7:0] of entry ptr_i[3:0] and copies the entry into the staging register. Reads with index 1 and 2 return staging bits [15:8] and [23:16], whatever entry the pointer selects.
- R9: Table accesses act only when the low byte is below 0x10, and each such access requests a triplet advance. A table access with a low byte of 0x10 or above returns 0, requests nothing and stores nothing.
- R10: rdata_o and the advance outputs are registered. They reflect the access of the previous cycle and are 0 after a cycle with no strobe. At most one advance output is high at a time. When rd_i and wr_i are both high, the write is performed and rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptr_i | input | 12 | Current pointer; [11:8] selects the space, [7:0] is the location |
| idx_i | input | 2 | Component index within a triplet |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte for the previous cycle's read |
| adv_trip_o | output | 1 | Pulse requesting a triplet (component) advance |
| adv_step_o | output | 1 | Pulse requesting a single-step pointer advance |

## Verification
A corrupted stored byte in this block cannot be seen directly. It shows up at rdata_o one cycle after the next read of that location. For table entries, bytes 1 and 2 appear only after a component-0 read has refreshed the staging register. A staging register left with stale upper bytes, or a commit made too early, shows up as wrong bytes on the read-back of a word written partially, or of a word written with component 1 skipped. Decode faults show up at once as an advance pulse of the wrong kind, or an unexpected one, in the cycle after the access. They are also caught one access later, when a neighbouring location reads back a value it was never given.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;

  typedef enum logic [1:0] {
    ADV_NONE = 2'd0,
    ADV_STEP = 2'd1,
    ADV_TRIP = 2'd2
  } adv_e;

  localparam logic [3:0] SPACE_CUR = 4'h1;
  localparam logic [3:0] SPACE_REG = 4'h2;
  localparam logic [3:0] SPACE_WTT = 4'h3;

endpackage

// File: rtl/ctl_regs.sv
module ctl_regs
  import ctl_dec_pkg::*;
#(
  parameter int              DW        = 8,
  parameter int              IW        = 2,
  parameter int              N_REG     = 16,
  parameter int              WIDE_BASE = 14,
  parameter logic [7:0]      REV_LOC   = 8'h20,
  parameter logic [DW-1:0]   ID_CODE   = 8'h2A,
  parameter logic [DW-1:0]   REV_CODE  = 8'h0A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    ptr_lo_i,
  input  logic [IW-1:0] idx_i,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output adv_e          adv_o
);

  localparam int SW    = $clog2(N_REG);
  localparam int NCOMP = 3;
  localparam int NSLOT = 2 ** IW;

  logic          in_low;
  logic          is_rev;
  logic [SW-1:0] sel;
  logic [DW-1:0] rd_g [N_REG];

  assign in_low = ptr_lo_i < 8'(N_REG);
  assign is_rev = ptr_lo_i == REV_LOC;
  assign sel    = ptr_lo_i[SW-1:0];

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    if (g == 0) begin : g_id
      assign rd_g[g] = ID_CODE;
    end else if (g >= WIDE_BASE) begin : g_wide
      logic [DW-1:0] b_q [NSLOT];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int k = 0; k < NSLOT; k++) b_q[k] <= '0;
        end else if (wr_en_i && in_low && sel == SW'(g) && int'(idx_i) < NCOMP) begin
          b_q[idx_i] <= wdata_i;
        end
      end
      // slot 3 is never written, so it reads as zero
      assign rd_g[g] = b_q[idx_i];
    end else begin : g_byte
      logic [DW-1:0] b_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                b_q <= '0;
        else if (wr_en_i && in_low && sel == SW'(g)) b_q <= wdata_i;
      end
      assign rd_g[g] = b_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    adv_o   = ADV_NONE;
    if (in_low) begin
      rdata_o = rd_g[sel];
      if (rd_en_i || wr_en_i) adv_o = (int'(sel) >= WIDE_BASE) ? ADV_TRIP : ADV_STEP;
    end else if (is_rev) begin
      rdata_o = REV_CODE;
      if (rd_en_i) adv_o = ADV_STEP;
    end
  end

endmodule

// File: rtl/ctl_cursor.sv
module ctl_cursor
  import ctl_dec_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IW    = 2,
  parameter int N_ENT = 4,
  parameter int N_RD  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    ptr_lo_i,
  input  logic [IW-1:0] idx_i,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output adv_e          adv_o
);

  localparam int EW    = $clog2(N_ENT);
  localparam int NCOMP = 3;
  localparam int NSLOT = 2 ** IW;

  logic [NSLOT-1:0][DW-1:0] cur_q [N_ENT];
  logic                     wr_ok, rd_ok;
  logic [EW-1:0]            ent;

  assign ent   = ptr_lo_i[EW-1:0];
  assign wr_ok = ptr_lo_i < 8'(N_ENT);
  assign rd_ok = ptr_lo_i < 8'(N_RD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N_ENT; e++) cur_q[e] <= '0;
    end else if (wr_en_i && wr_ok && int'(idx_i) < NCOMP) begin
      cur_q[ent][idx_i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = rd_ok ? cur_q[ent][idx_i] : '0;
    adv_o   = ((wr_en_i && wr_ok) || (rd_en_i && rd_ok)) ? ADV_TRIP : ADV_NONE;
  end

`ifndef SYNTHESIS
  p_cur_store_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_ok && int'(idx_i) < NCOMP) |=>
      cur_q[$past(ent)][$past(idx_i)] == $past(wdata_i));
`endif

endmodule

// File: rtl/ctl_wtt.sv
module ctl_wtt
  import ctl_dec_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IW    = 2,
  parameter int DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    ptr_lo_i,
  input  logic [IW-1:0] idx_i,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output adv_e          adv_o
);

  localparam int AW = $clog2(DEPTH);
  localparam int WW = 3 * DW;

  logic [WW-1:0] entry_q [DEPTH];
  logic [WW-1:0] stage_q;
  logic [WW-1:0] word;
  logic [AW-1:0] a;
  logic          hit;

  assign a    = ptr_lo_i[AW-1:0];
  assign hit  = ptr_lo_i < 8'(DEPTH);
  assign word = entry_q[a];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      for (int e = 0; e < DEPTH; e++) entry_q[e] <= '0;
    end else if (hit && wr_en_i) begin
      unique case (idx_i)
        IW'(0): stage_q <= {{(WW-DW){1'b0}}, wdata_i};
        IW'(1): stage_q[2*DW-1:DW] <= wdata_i;
        IW'(2): begin
          stage_q[WW-1:2*DW] <= wdata_i;
          entry_q[a]         <= {wdata_i, stage_q[2*DW-1:0]};
        end
        default: ;
      endcase
    end else if (hit && rd_en_i && idx_i == IW'(0)) begin
      stage_q <= word;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      unique case (idx_i)
        IW'(0):  rdata_o = word[DW-1:0];
        IW'(1):  rdata_o = stage_q[2*DW-1:DW];
        IW'(2):  rdata_o = stage_q[WW-1:2*DW];
        default: rdata_o = '0;
      endcase
    end
    adv_o = (hit && (rd_en_i || wr_en_i)) ? ADV_TRIP : ADV_NONE;
  end

`ifndef SYNTHESIS
  p_commit_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && wr_en_i && idx_i == IW'(2)) |=>
      entry_q[$past(a)] == {$past(wdata_i), $past(stage_q[2*DW-1:0])});

  p_snapshot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && rd_en_i && !wr_en_i && idx_i == IW'(0)) |=> stage_q == $past(word));
`endif

endmodule

// File: rtl/ctl_space_dec.sv
module ctl_space_dec
  import ctl_dec_pkg::*;
#(
  parameter int            DW        = 8,
  parameter int            PW        = 12,
  parameter int            IW        = 2,
  parameter int            N_REG     = 16,
  parameter int            WIDE_BASE = 14,
  parameter int            N_CUR     = 4,
  parameter int            N_CUR_RD  = 2,
  parameter int            WTT_DEPTH = 16,
  parameter logic [DW-1:0] ID_CODE   = 8'h2A,
  parameter logic [DW-1:0] REV_CODE  = 8'h0A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] ptr_i,
  input  logic [IW-1:0] idx_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          adv_trip_o,
  output logic          adv_step_o
);

  logic [3:0]    space;
  logic [7:0]    ptr_lo;
  logic          rd_en, wr_en;
  logic          cur_sel, reg_sel, wtt_sel;
  logic [DW-1:0] cur_rd, reg_rd, wtt_rd, sel_rd;
  adv_e          cur_adv, reg_adv, wtt_adv, sel_adv;

  assign space   = ptr_i[PW-1:PW-4];
  assign ptr_lo  = ptr_i[7:0];
  assign wr_en   = wr_i;
  assign rd_en   = rd_i && !wr_i;  // write takes precedence
  assign cur_sel = space == SPACE_CUR;
  assign reg_sel = space == SPACE_REG;
  assign wtt_sel = space == SPACE_WTT;

  ctl_cursor #(.DW(DW), .IW(IW), .N_ENT(N_CUR), .N_RD(N_CUR_RD)) i_cursor (
    .clk_i, .rst_ni, .ptr_lo_i(ptr_lo), .idx_i,
    .rd_en_i(rd_en && cur_sel), .wr_en_i(wr_en && cur_sel), .wdata_i,
    .rdata_o(cur_rd), .adv_o(cur_adv)
  );

  ctl_regs #(.DW(DW), .IW(IW), .N_REG(N_REG), .WIDE_BASE(WIDE_BASE),
             .ID_CODE(ID_CODE), .REV_CODE(REV_CODE)) i_regs (
    .clk_i, .rst_ni, .ptr_lo_i(ptr_lo), .idx_i,
    .rd_en_i(rd_en && reg_sel), .wr_en_i(wr_en && reg_sel), .wdata_i,
    .rdata_o(reg_rd), .adv_o(reg_adv)
  );

  ctl_wtt #(.DW(DW), .IW(IW), .DEPTH(WTT_DEPTH)) i_wtt (
    .clk_i, .rst_ni, .ptr_lo_i(ptr_lo), .idx_i,
    .rd_en_i(rd_en && wtt_sel), .wr_en_i(wr_en && wtt_sel), .wdata_i,
    .rdata_o(wtt_rd), .adv_o(wtt_adv)
  );

  always_comb begin
    sel_rd  = '0;
    sel_adv = ADV_NONE;
    unique case (space)
      SPACE_CUR: begin sel_rd = cur_rd; sel_adv = cur_adv; end
      SPACE_REG: begin sel_rd = reg_rd; sel_adv = reg_adv; end
      SPACE_WTT: begin sel_rd = wtt_rd; sel_adv = wtt_adv; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o    <= '0;
      adv_trip_o <= 1'b0;
      adv_step_o <= 1'b0;
    end else begin
      rdata_o    <= rd_en ? sel_rd : '0;
      adv_trip_o <= sel_adv == ADV_TRIP;
      adv_step_o <= sel_adv == ADV_STEP;
    end
  end

`ifndef SYNTHESIS
  p_adv_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({adv_trip_o, adv_step_o}));

  p_adv_needs_access_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i || wr_i) |=> !adv_trip_o && !adv_step_o && rdata_o == '0);

  p_id_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && reg_sel && ptr_lo == 8'h00) |=> rdata_o == ID_CODE && adv_step_o);

  p_other_space_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && !cur_sel && !reg_sel && !wtt_sel) |=>
      !adv_trip_o && !adv_step_o && rdata_o == '0);
`endif

endmodule

// File: tb/test_ctl_space_dec.sv
`timescale 1ns/1ps
module test_ctl_space_dec;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] ptr_i = '0;
  logic [1:0]  idx_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        adv_trip_o, adv_step_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ctl_space_dec i_ctl_space_dec (.*);

  // {req[37:34], wr, rd, ptr[31:20], idx[19:18], wdata[17:10], exp_rd[9:2], trip, step}
  localparam int NV = 57;
  localparam logic [37:0] VEC [NV] = '{
    {4'd3, 1'b0,1'b1,12'h200,2'd0,8'h00,8'h2A,1'b0,1'b1}, // R3 ID
    {4'd3, 1'b0,1'b1,12'h220,2'd0,8'h00,8'h0A,1'b0,1'b1}, // R3 revision
    {4'd3, 1'b1,1'b0,12'h200,2'd0,8'h55,8'h00,1'b0,1'b1}, // R3 ID write ignored
    {4'd3, 1'b0,1'b1,12'h200,2'd1,8'h00,8'h2A,1'b0,1'b1},
    {4'd4, 1'b1,1'b0,12'h205,2'd0,8'h11,8'h00,1'b0,1'b1}, // R4
    {4'd4, 1'b0,1'b1,12'h205,2'd2,8'h00,8'h11,1'b0,1'b1},
    {4'd4, 1'b1,1'b0,12'h20D,2'd3,8'h9C,8'h00,1'b0,1'b1},
    {4'd4, 1'b0,1'b1,12'h20D,2'd0,8'h00,8'h9C,1'b0,1'b1},
    {4'd5, 1'b1,1'b0,12'h20E,2'd0,8'hA1,8'h00,1'b1,1'b0}, // R5
    {4'd5, 1'b1,1'b0,12'h20E,2'd1,8'hA2,8'h00,1'b1,1'b0},
    {4'd5, 1'b1,1'b0,12'h20E,2'd2,8'hA3,8'h00,1'b1,1'b0},
    {4'd5, 1'b0,1'b1,12'h20E,2'd1,8'h00,8'hA2,1'b1,1'b0},
    {4'd5, 1'b0,1'b1,12'h20E,2'd2,8'h00,8'hA3,1'b1,1'b0},
    {4'd5, 1'b0,1'b1,12'h20F,2'd0,8'h00,8'h00,1'b1,1'b0},
    {4'd5, 1'b1,1'b0,12'h20E,2'd3,8'hFF,8'h00,1'b1,1'b0},
    {4'd5, 1'b0,1'b1,12'h20E,2'd3,8'h00,8'h00,1'b1,1'b0},
    {4'd5, 1'b0,1'b1,12'h20E,2'd0,8'h00,8'hA1,1'b1,1'b0},
    {4'd3, 1'b1,1'b0,12'h220,2'd0,8'h77,8'h00,1'b0,1'b0}, // R3 invalid locations
    {4'd3, 1'b0,1'b1,12'h211,2'd0,8'h00,8'h00,1'b0,1'b0},
    {4'd3, 1'b1,1'b0,12'h211,2'd0,8'h77,8'h00,1'b0,1'b0},
    {4'd6, 1'b1,1'b0,12'h100,2'd0,8'hC0,8'h00,1'b1,1'b0}, // R6
    {4'd6, 1'b1,1'b0,12'h101,2'd2,8'hC5,8'h00,1'b1,1'b0},
    {4'd6, 1'b1,1'b0,12'h102,2'd1,8'hD1,8'h00,1'b1,1'b0},
    {4'd6, 1'b1,1'b0,12'h103,2'd0,8'hD3,8'h00,1'b1,1'b0},
    {4'd6, 1'b1,1'b0,12'h104,2'd0,8'hEE,8'h00,1'b0,1'b0},
    {4'd6, 1'b0,1'b1,12'h100,2'd0,8'h00,8'hC0,1'b1,1'b0},
    {4'd6, 1'b0,1'b1,12'h101,2'd2,8'h00,8'hC5,1'b1,1'b0},
    {4'd6, 1'b0,1'b1,12'h101,2'd1,8'h00,8'h00,1'b1,1'b0},
    {4'd6, 1'b0,1'b1,12'h102,2'd1,8'h00,8'h00,1'b0,1'b0},
    {4'd6, 1'b0,1'b1,12'h100,2'd1,8'h00,8'h00,1'b1,1'b0},
    {4'd7, 1'b1,1'b0,12'h303,2'd0,8'h12,8'h00,1'b1,1'b0}, // R7 partial word
    {4'd7, 1'b1,1'b0,12'h303,2'd1,8'h34,8'h00,1'b1,1'b0},
    {4'd7, 1'b0,1'b1,12'h303,2'd0,8'h00,8'h00,1'b1,1'b0},
    {4'd7, 1'b1,1'b0,12'h303,2'd0,8'h12,8'h00,1'b1,1'b0},
    {4'd7, 1'b1,1'b0,12'h303,2'd1,8'h34,8'h00,1'b1,1'b0},
    {4'd7, 1'b1,1'b0,12'h303,2'd2,8'h56,8'h00,1'b1,1'b0},
    {4'd7, 1'b0,1'b1,12'h303,2'd0,8'h00,8'h12,1'b1,1'b0},
    {4'd7, 1'b0,1'b1,12'h303,2'd1,8'h00,8'h34,1'b1,1'b0},
    {4'd7, 1'b0,1'b1,12'h303,2'd2,8'h00,8'h56,1'b1,1'b0},
    {4'd7, 1'b1,1'b0,12'h307,2'd0,8'hAA,8'h00,1'b1,1'b0}, // R7 upper cleared
    {4'd7, 1'b1,1'b0,12'h307,2'd2,8'hBB,8'h00,1'b1,1'b0},
    {4'd7, 1'b0,1'b1,12'h307,2'd0,8'h00,8'hAA,1'b1,1'b0},
    {4'd7, 1'b0,1'b1,12'h307,2'd1,8'h00,8'h00,1'b1,1'b0},
    {4'd7, 1'b0,1'b1,12'h307,2'd2,8'h00,8'hBB,1'b1,1'b0},
    {4'd8, 1'b0,1'b1,12'h303,2'd0,8'h00,8'h12,1'b1,1'b0}, // R8 snapshot
    {4'd8, 1'b0,1'b1,12'h307,2'd1,8'h00,8'h34,1'b1,1'b0},
    {4'd8, 1'b0,1'b1,12'h307,2'd2,8'h00,8'h56,1'b1,1'b0},
    {4'd9, 1'b0,1'b1,12'h310,2'd0,8'h00,8'h00,1'b0,1'b0}, // R9
    {4'd9, 1'b1,1'b0,12'h310,2'd2,8'h99,8'h00,1'b0,1'b0},
    {4'd9, 1'b0,1'b1,12'h300,2'd0,8'h00,8'h00,1'b1,1'b0},
    {4'd9, 1'b1,1'b0,12'h313,2'd2,8'h99,8'h00,1'b0,1'b0},
    {4'd9, 1'b0,1'b1,12'h303,2'd0,8'h00,8'h12,1'b1,1'b0},
    {4'd2, 1'b0,1'b1,12'h000,2'd0,8'h00,8'h00,1'b0,1'b0}, // R2
    {4'd2, 1'b1,1'b0,12'h405,2'd0,8'h66,8'h00,1'b0,1'b0},
    {4'd2, 1'b0,1'b1,12'hF20,2'd0,8'h00,8'h00,1'b0,1'b0},
    {4'd2, 1'b0,1'b1,12'h205,2'd0,8'h00,8'h11,1'b0,1'b1},
    {4'd10,1'b0,1'b0,12'h205,2'd0,8'h00,8'h00,1'b0,1'b0}  // R10 idle
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [7:0] rd, input logic tr, input logic st);
    check(req, "rdata", int'(rdata_o), int'(rd));
    check(req, "trip", int'(adv_trip_o), int'(tr));
    check(req, "step", int'(adv_step_o), int'(st));
  endtask

  // drive at negedge, outputs registered at posedge, sample at next negedge
  task automatic acc(input logic w, input logic r, input logic [11:0] p,
                     input logic [1:0] i, input logic [7:0] d);
    wr_i = w; rd_i = r; ptr_i = p; idx_i = i; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check_out("R1", 8'h00, 1'b0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < NV; v++) begin
      logic [37:0] r;
      r = VEC[v];
      acc(r[33], r[32], r[31:20], r[19:18], r[17:10]);
      check_out($sformatf("R%0d", r[37:34]), r[9:2], r[1], r[0]);
    end

    // R10 write precedence, then pulse width
    acc(1'b1, 1'b1, 12'h205, 2'd0, 8'h66);
    check_out("R10", 8'h00, 1'b0, 1'b1);
    @(negedge clk_i);
    check_out("R10", 8'h00, 1'b0, 1'b0);
    acc(1'b0, 1'b1, 12'h205, 2'd0, 8'h00);
    check_out("R10", 8'h66, 1'b0, 1'b1);

    // R1 reset clears storage
    acc(1'b0, 1'b1, 12'h20E, 2'd2, 8'h00);
    rst_ni = 1'b0;
    #1;
    check_out("R1", 8'h00, 1'b0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    acc(1'b0, 1'b1, 12'h205, 2'd0, 8'h00);
    check_out("R1", 8'h00, 1'b0, 1'b1);
    acc(1'b0, 1'b1, 12'h20E, 2'd1, 8'h00);
    check_out("R1", 8'h00, 1'b1, 1'b0);
    acc(1'b0, 1'b1, 12'h100, 2'd0, 8'h00);
    check_out("R1", 8'h00, 1'b1, 1'b0);
    acc(1'b0, 1'b1, 12'h303, 2'd0, 8'h00);
    check_out("R1", 8'h00, 1'b1, 1'b0);
    acc(1'b0, 1'b1, 12'h303, 2'd2, 8'h00);
    check_out("R1", 8'h00, 1'b1, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule